// File: doc/BRIEF.md
# Mode-Controlled Frame Data Buffer

This block sits between a demodulator that delivers bytes and an output stage that drains them. Incoming bytes are grouped into frames of a fixed size. A two-bit mode input picks one of three behaviours:

- **Discard** throws away everything buffered and clears the pointers.
- **Freeze** stops writing while reads continue.
- **Run** writes and reads normally.

Reads are refused until a minimum number of whole frames has accumulated. A frame count is offered to a host for monitoring.

Entry into and exit from freeze is aligned to a block-start strobe. This lets the host stop the write stream at a known block boundary, step the source back, and restart at that same boundary without a gap or a duplicate. Once read-out has been enabled, it stays enabled while data remains. This means a stream that has started keeps flowing down to empty.

Top module: `frame_fifo`

## Requirements
- R1: `mode_i` encoding is 0 = discard, 1 = freeze, 2 or 3 = run. On any clock edge where `mode_i` is 0:
  - the frame count, occupancy, `rd_ready_o`, `overflow_o` and `hold_o` become 0;
  - no write is stored;
  - the next cycle shows `rd_valid_o` low.
- R2: `hold_o` rises only at an edge where `blk_start_i` is high and `mode_i` is 1. A byte offered together with that strobe, and every later byte until release, is not stored.
- R3: `hold_o` falls at an edge where `blk_start_i` is high and `mode_i` is not 1. A byte offered together with that strobe is stored.
- R4: While `hold_o` is high, reads keep returning buffered data if `rd_ready_o` was already high.
- R5: Accepted bytes are read back in write order. A read request accepted at an edge gives `rd_valid_o` high with the byte on `rd_data_o` right after that edge.
- R6: `rd_ready_o` rises at the same edge at which `frame_cnt_o` reaches MIN_FRAMES, and never rises below it.
- R7: Once high, `rd_ready_o` stays high until the last buffered byte is read or discard mode is applied.
- R8: A read request while `rd_ready_o` is low returns `rd_valid_o` low and removes nothing.
- R9: `frame_cnt_o` equals the number of fully written frames minus the number of fully read frames. It changes by at most one per cycle.
- R10: A write offered while FRAME_BYTES*DEPTH_FRAMES bytes are held is dropped and sets `overflow_o`. `overflow_o` stays set until discard mode or reset.
- R11: After reset, the following are all low or zero: `frame_cnt_o`, `rd_ready_o`, `rd_valid_o`, `hold_o` and `overflow_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | 0 discard, 1 freeze, 2/3 run |
| blk_start_i | input | 1 | Block-start strobe aligning freeze changes |
| wr_valid_i | input | 1 | Byte offered by the demodulator |
| wr_data_i | input | DATA_W | Offered byte |
| rd_req_i | input | 1 | Read request from the output stage |
| rd_valid_o | output | 1 | `rd_data_o` holds a byte read at the previous edge |
| rd_data_o | output | DATA_W | Byte read out |
| rd_ready_o | output | 1 | Read-out enabled |
| frame_cnt_o | output | $clog2(DEPTH_FRAMES+1) | Whole frames held |
| hold_o | output | 1 | Freeze applied |
| overflow_o | output | 1 | Sticky dropped-write flag |

## Verification
An internal pointer that slips shows up at the first read after the fault as a byte out of sequence on `rd_data_o`. A wrong byte-in-frame counter instead shows up as `frame_cnt_o` stepping one write too early or too late. A freeze latch updated on the wrong edge admits or drops the byte that travels with the block-start strobe. That byte therefore appears, or goes missing, in the read-back stream. A read-enable latch that releases early makes `rd_valid_o` fall while `frame_cnt_o` is still nonzero, and this is visible on the very next request.

// File: rtl/frame_fifo_pkg.sv
package frame_fifo_pkg;
  typedef enum logic [1:0] {
    MODE_DISCARD = 2'd0,
    MODE_FREEZE  = 2'd1,
    MODE_RUN     = 2'd2,
    MODE_RUN_ALT = 2'd3
  } fifo_mode_e;
endpackage

// File: rtl/frame_fifo_mode.sv
module frame_fifo_mode
  import frame_fifo_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode_i,
  input  logic       blk_start_i,
  output logic       discard_o,
  output logic       wr_gate_o,
  output logic       hold_o
);
  logic hold_q;
  logic hold_next;

  // Discard acts at once; freeze changes wait for the block strobe.
  always_comb begin
    discard_o = (mode_i == MODE_DISCARD);
    if (discard_o)
      hold_next = 1'b0;
    else if (blk_start_i)
      hold_next = (mode_i == MODE_FREEZE);
    else
      hold_next = hold_q;
    // The byte riding with the strobe follows the new state.
    wr_gate_o = !discard_o && !hold_next;
  end

  always_ff @(posedge clk) begin
    if (rst) hold_q <= 1'b0;
    else     hold_q <= hold_next;
  end

  assign hold_o = hold_q;
endmodule

// File: rtl/frame_fifo_ptr.sv
module frame_fifo_ptr #(
  parameter int DEPTH_BYTES = 2880,
  parameter int FRAME_BYTES = 24
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           clr,
  input  logic                           adv,
  output logic [$clog2(DEPTH_BYTES)-1:0] ptr_o,
  output logic                           frame_end_o
);
  localparam int AW = $clog2(DEPTH_BYTES);
  localparam int BW = (FRAME_BYTES > 1) ? $clog2(FRAME_BYTES) : 1;

  logic [AW-1:0] ptr_q;
  logic [BW-1:0] idx_q;
  logic          ptr_wrap;
  logic          idx_wrap;

  assign ptr_wrap    = (ptr_q == AW'(DEPTH_BYTES - 1));
  assign idx_wrap    = (idx_q == BW'(FRAME_BYTES - 1));
  assign frame_end_o = adv && idx_wrap;
  assign ptr_o       = ptr_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      ptr_q <= '0;
      idx_q <= '0;
    end else if (adv) begin
      ptr_q <= ptr_wrap ? '0 : ptr_q + AW'(1);
      idx_q <= idx_wrap ? '0 : idx_q + BW'(1);
    end
  end
endmodule

// File: rtl/frame_fifo_ram.sv
module frame_fifo_ram #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 2880,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/frame_fifo.sv
module frame_fifo
  import frame_fifo_pkg::*;
#(
  parameter int DATA_W       = 8,
  parameter int FRAME_BYTES  = 24,
  parameter int MIN_FRAMES   = 110,
  parameter int DEPTH_FRAMES = 120
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [1:0]                        mode_i,
  input  logic                              blk_start_i,
  input  logic                              wr_valid_i,
  input  logic [DATA_W-1:0]                 wr_data_i,
  input  logic                              rd_req_i,
  output logic                              rd_valid_o,
  output logic [DATA_W-1:0]                 rd_data_o,
  output logic                              rd_ready_o,
  output logic [$clog2(DEPTH_FRAMES+1)-1:0] frame_cnt_o,
  output logic                              hold_o,
  output logic                              overflow_o
);
  localparam int DEPTH_BYTES = FRAME_BYTES * DEPTH_FRAMES;
  localparam int AW          = $clog2(DEPTH_BYTES);
  localparam int OW          = $clog2(DEPTH_BYTES + 1);
  localparam int FCW         = $clog2(DEPTH_FRAMES + 1);

  logic           discard;
  logic           wr_gate;
  logic           full;
  logic           empty;
  logic           wr_acc;
  logic           wr_drop;
  logic           rd_acc;
  logic           wr_fend;
  logic           rd_fend;
  logic [AW-1:0]  wr_ptr;
  logic [AW-1:0]  rd_ptr;
  logic [OW-1:0]  occ_q;
  logic [OW-1:0]  occ_next;
  logic [FCW-1:0] frames_q;
  logic [FCW-1:0] frames_next;
  logic           ready_q;
  logic           ready_next;
  logic           ovf_q;
  logic           ovf_next;
  logic           rvalid_q;

  frame_fifo_mode u_mode (
    .clk        (clk),
    .rst        (rst),
    .mode_i     (mode_i),
    .blk_start_i(blk_start_i),
    .discard_o  (discard),
    .wr_gate_o  (wr_gate),
    .hold_o     (hold_o)
  );

  assign full    = (occ_q == OW'(DEPTH_BYTES));
  assign empty   = (occ_q == '0);
  assign wr_acc  = wr_valid_i && wr_gate && !full;
  assign wr_drop = wr_valid_i && wr_gate && full;
  assign rd_acc  = rd_req_i && ready_q && !empty && !discard;

  frame_fifo_ptr #(.DEPTH_BYTES(DEPTH_BYTES), .FRAME_BYTES(FRAME_BYTES)) u_wptr (
    .clk        (clk),
    .rst        (rst),
    .clr        (discard),
    .adv        (wr_acc),
    .ptr_o      (wr_ptr),
    .frame_end_o(wr_fend)
  );

  frame_fifo_ptr #(.DEPTH_BYTES(DEPTH_BYTES), .FRAME_BYTES(FRAME_BYTES)) u_rptr (
    .clk        (clk),
    .rst        (rst),
    .clr        (discard),
    .adv        (rd_acc),
    .ptr_o      (rd_ptr),
    .frame_end_o(rd_fend)
  );

  frame_fifo_ram #(.DATA_W(DATA_W), .DEPTH(DEPTH_BYTES), .AW(AW)) u_ram (
    .clk  (clk),
    .we   (wr_acc),
    .waddr(wr_ptr),
    .wdata(wr_data_i),
    .re   (rd_acc),
    .raddr(rd_ptr),
    .rdata(rd_data_o)
  );

  always_comb begin
    occ_next    = occ_q;
    frames_next = frames_q;
    if (discard) begin
      occ_next    = '0;
      frames_next = '0;
    end else begin
      if (wr_acc && !rd_acc)      occ_next = occ_q + OW'(1);
      else if (rd_acc && !wr_acc) occ_next = occ_q - OW'(1);
      if (wr_fend && !rd_fend)      frames_next = frames_q + FCW'(1);
      else if (rd_fend && !wr_fend) frames_next = frames_q - FCW'(1);
    end

    if (discard || occ_next == '0)
      ready_next = 1'b0;
    else if (32'(frames_next) >= MIN_FRAMES)
      ready_next = 1'b1;
    else
      ready_next = ready_q;

    ovf_next = discard ? 1'b0 : (ovf_q || wr_drop);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      occ_q    <= '0;
      frames_q <= '0;
      ready_q  <= 1'b0;
      ovf_q    <= 1'b0;
      rvalid_q <= 1'b0;
    end else begin
      occ_q    <= occ_next;
      frames_q <= frames_next;
      ready_q  <= ready_next;
      ovf_q    <= ovf_next;
      rvalid_q <= rd_acc;
    end
  end

  assign rd_valid_o  = rvalid_q;
  assign rd_ready_o  = ready_q;
  assign frame_cnt_o = frames_q;
  assign overflow_o  = ovf_q;
endmodule

// File: rtl/frame_fifo_chk.sv
module frame_fifo_chk #(
  parameter int FCW        = 7,
  parameter int MIN_FRAMES = 110
) (
  input logic           clk,
  input logic           rst,
  input logic [1:0]     mode_i,
  input logic           blk_start_i,
  input logic           rd_req_i,
  input logic           rd_valid_o,
  input logic           rd_ready_o,
  input logic [FCW-1:0] frame_cnt_o,
  input logic           hold_o,
  input logic           overflow_o
);
  assert_discard_clears_R1: assert property (@(posedge clk) disable iff (rst)
    (mode_i == 2'd0) |=> (frame_cnt_o == '0 && !rd_ready_o && !overflow_o && !hold_o && !rd_valid_o));

  assert_hold_only_on_strobe_R2: assert property (@(posedge clk) disable iff (rst)
    (!blk_start_i && mode_i != 2'd0) |=> $stable(hold_o));

  assert_frozen_no_growth_R2: assert property (@(posedge clk) disable iff (rst)
    (hold_o && !blk_start_i && mode_i != 2'd0) |=> (frame_cnt_o <= $past(frame_cnt_o)));

  assert_release_on_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (hold_o && blk_start_i && mode_i >= 2'd2) |=> !hold_o);

  assert_ready_at_threshold_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_ready_o) |-> (32'(frame_cnt_o) >= MIN_FRAMES));

  assert_ready_persists_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_ready_o && mode_i != 2'd0 && frame_cnt_o >= FCW'(2)) |=> rd_ready_o);

  assert_no_read_unready_R8: assert property (@(posedge clk) disable iff (rst)
    (rd_req_i && !rd_ready_o) |=> !rd_valid_o);

  assert_count_single_step_R9: assert property (@(posedge clk) disable iff (rst)
    (mode_i != 2'd0) |=> (frame_cnt_o == $past(frame_cnt_o) ||
                          frame_cnt_o == $past(frame_cnt_o) + FCW'(1) ||
                          frame_cnt_o == $past(frame_cnt_o) - FCW'(1)));

  assert_overflow_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (overflow_o && mode_i != 2'd0) |=> overflow_o);
endmodule

bind frame_fifo frame_fifo_chk #(.FCW(FCW), .MIN_FRAMES(MIN_FRAMES)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .mode_i     (mode_i),
  .blk_start_i(blk_start_i),
  .rd_req_i   (rd_req_i),
  .rd_valid_o (rd_valid_o),
  .rd_ready_o (rd_ready_o),
  .frame_cnt_o(frame_cnt_o),
  .hold_o     (hold_o),
  .overflow_o (overflow_o)
);

// File: tb/frame_fifo_test.sv
module frame_fifo_test;
  localparam int DW  = 8;
  localparam int FB  = 4;
  localparam int MIN = 3;
  localparam int DF  = 5;
  localparam int FCW = $clog2(DF + 1);

  logic           clk = 1'b0;
  logic           rst;
  logic [1:0]     mode_i;
  logic           blk_start_i;
  logic           wr_valid_i;
  logic [DW-1:0]  wr_data_i;
  logic           rd_req_i;
  logic           rd_valid_o;
  logic [DW-1:0]  rd_data_o;
  logic           rd_ready_o;
  logic [FCW-1:0] frame_cnt_o;
  logic           hold_o;
  logic           overflow_o;

  int compared   = 0;
  int mismatched = 0;
  bit finished   = 1'b0;

  always #10 clk = ~clk;

  frame_fifo #(.DATA_W(DW), .FRAME_BYTES(FB), .MIN_FRAMES(MIN), .DEPTH_FRAMES(DF)) uut (
    .clk(clk), .rst(rst), .mode_i(mode_i), .blk_start_i(blk_start_i),
    .wr_valid_i(wr_valid_i), .wr_data_i(wr_data_i), .rd_req_i(rd_req_i),
    .rd_valid_o(rd_valid_o), .rd_data_o(rd_data_o), .rd_ready_o(rd_ready_o),
    .frame_cnt_o(frame_cnt_o), .hold_o(hold_o), .overflow_o(overflow_o)
  );

  typedef struct packed {
    logic [1:0] mode;
    logic       blk;
    logic       wv;
    logic [3:0] reps;
    logic [2:0] frames;
    logic       ready;
    logic       hold;
    logic       ovf;
  } step_t;

  // Run = 2, freeze = 1, discard = 0; strobe only on the first repetition.
  localparam step_t TBL [10] = '{
    '{2'd2, 1'b0, 1'b1, 4'd4, 3'd1, 1'b0, 1'b0, 1'b0},  // R9 first frame
    '{2'd2, 1'b0, 1'b1, 4'd7, 3'd2, 1'b0, 1'b0, 1'b0},  // R9 partial frame not counted
    '{2'd2, 1'b0, 1'b1, 4'd1, 3'd3, 1'b1, 1'b0, 1'b0},  // R6 threshold reached
    '{2'd1, 1'b0, 1'b1, 4'd4, 3'd4, 1'b1, 1'b0, 1'b0},  // R2 freeze waits for strobe
    '{2'd1, 1'b1, 1'b1, 4'd1, 3'd4, 1'b1, 1'b1, 1'b0},  // R2 strobe byte dropped
    '{2'd1, 1'b0, 1'b1, 4'd3, 3'd4, 1'b1, 1'b1, 1'b0},  // R2 frozen
    '{2'd2, 1'b0, 1'b1, 4'd2, 3'd4, 1'b1, 1'b1, 1'b0},  // R3 release waits for strobe
    '{2'd2, 1'b1, 1'b1, 4'd4, 3'd5, 1'b1, 1'b0, 1'b0},  // R3 strobe byte stored
    '{2'd2, 1'b0, 1'b1, 4'd1, 3'd5, 1'b1, 1'b0, 1'b1},  // R10 overflow
    '{2'd0, 1'b0, 1'b1, 4'd1, 3'd0, 1'b0, 1'b0, 1'b0}   // R1 discard clears
  };

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] d, input logic blk);
    wr_valid_i  = 1'b1;
    wr_data_i   = d;
    blk_start_i = blk;
    tick();
    wr_valid_i  = 1'b0;
    blk_start_i = 1'b0;
  endtask

  task automatic get_chk(input string req, input logic [7:0] exp);
    rd_req_i = 1'b1;
    tick();
    rd_req_i = 1'b0;
    chk({req, " valid"}, int'(rd_valid_o), 1);
    chk({req, " data"}, int'(rd_data_o), int'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; mode_i = 2'd2; blk_start_i = 1'b0; wr_valid_i = 1'b0;
    wr_data_i = '0; rd_req_i = 1'b0;
    repeat (3) tick();
    rst = 1'b0;
    tick();

    // R11 reset state
    chk("R11 frames", int'(frame_cnt_o), 0);
    chk("R11 ready", int'(rd_ready_o), 0);
    chk("R11 valid", int'(rd_valid_o), 0);
    chk("R11 hold", int'(hold_o), 0);
    chk("R11 overflow", int'(overflow_o), 0);

    // Vector walk
    for (int i = 0; i < 10; i++) begin
      mode_i = TBL[i].mode;
      for (int r = 0; r < int'(TBL[i].reps); r++) begin
        blk_start_i = (r == 0) ? TBL[i].blk : 1'b0;
        wr_valid_i  = TBL[i].wv;
        wr_data_i   = 8'(i * 16 + r);
        tick();
      end
      blk_start_i = 1'b0;
      wr_valid_i  = 1'b0;
      chk($sformatf("R9 step %0d frames", i), int'(frame_cnt_o), int'(TBL[i].frames));
      chk($sformatf("R6/R7 step %0d ready", i), int'(rd_ready_o), int'(TBL[i].ready));
      chk($sformatf("R2/R3 step %0d hold", i), int'(hold_o), int'(TBL[i].hold));
      chk($sformatf("R10 step %0d overflow", i), int'(overflow_o), int'(TBL[i].ovf));
    end

    // R8: request below threshold
    mode_i = 2'd2;
    tick();
    for (int k = 0; k < 8; k++) put(8'(8'h40 + k), 1'b0);
    rd_req_i = 1'b1;
    tick();
    rd_req_i = 1'b0;
    chk("R8 unready read valid", int'(rd_valid_o), 0);
    chk("R8 nothing removed", int'(frame_cnt_o), 2);
    for (int k = 8; k < 12; k++) put(8'(8'h40 + k), 1'b0);
    chk("R6 ready at three frames", int'(rd_ready_o), 1);

    // R5 ordered read-back, R7 persistence, R9 count on reads
    for (int k = 0; k < 12; k++) begin
      get_chk("R5", 8'(8'h40 + k));
      if (k == 3) begin
        chk("R9 frame read out", int'(frame_cnt_o), 2);
        chk("R7 ready held below threshold", int'(rd_ready_o), 1);
      end
    end
    chk("R7 ready drops on empty", int'(rd_ready_o), 0);
    chk("R9 empty count", int'(frame_cnt_o), 0);
    rd_req_i = 1'b1;
    tick();
    rd_req_i = 1'b0;
    chk("R8 read after empty", int'(rd_valid_o), 0);

    // R4 reads during freeze, R3 strobe byte kept on release
    for (int k = 0; k < 12; k++) put(8'(8'h80 + k), 1'b0);
    mode_i = 2'd1;
    put(8'hEE, 1'b1);
    chk("R2 frozen", int'(hold_o), 1);
    get_chk("R4", 8'h80);
    get_chk("R4", 8'h81);
    mode_i = 2'd2;
    put(8'hA0, 1'b1);
    chk("R3 released", int'(hold_o), 0);
    for (int k = 1; k < 4; k++) put(8'(8'hA0 + k), 1'b0);
    chk("R3 count after release", int'(frame_cnt_o), 4);
    for (int k = 2; k < 12; k++) get_chk("R3/R5", 8'(8'h80 + k));
    for (int k = 0; k < 4; k++) get_chk("R3 strobe byte", 8'(8'hA0 + k));

    // R1 discard with data held and a pending request
    for (int k = 0; k < 12; k++) put(8'(k), 1'b0);
    mode_i   = 2'd0;
    rd_req_i = 1'b1;
    tick();
    rd_req_i = 1'b0;
    chk("R1 no valid in discard", int'(rd_valid_o), 0);
    chk("R1 count cleared", int'(frame_cnt_o), 0);
    chk("R1 ready cleared", int'(rd_ready_o), 0);
    mode_i = 2'd2;
    put(8'h11, 1'b0);
    chk("R1 no stale frames", int'(frame_cnt_o), 0);

    finished = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule